// File: doc/BRIEF.md
# Descriptor DMA Transfer Engine

This block moves 8-bit or 16-bit data over a simple synchronous memory port. A set of registers holds the mode, a transfer count, a source word, an operand address and a destination address. The set is loaded through one strobe while the engine is idle. A request input starts the work. The engine then reads memory, optionally adds two operands, and writes the result to the destination.

Three data paths are available:
- **Copy:** memory is copied to memory.
- **Immediate:** the source register itself is the value written, and the source is never read from memory.
- **Calculation:** the engine writes the sum of two operands. The first operand is either memory at the source address or the immediate value. The second operand is memory at the operand address.

In single mode, each request produces one transfer. In burst mode, one request runs transfers back to back until the count is exhausted. An interrupt-block output is high for as long as work is in progress. An optional end-of-transfer pulse marks the count reaching zero.

The memory port is byte addressed and little endian. It returns read data one cycle after a read is issued.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, `mem_req`, `irq_block` and `done_irq` are 0 and `count_out` is 0.
- R2: In copy mode (`cfg_src_imm`=0, `cfg_calc`=0), each transfer reads at the source address and writes the value read to the destination. With `cfg_wide`=1 this moves 2 bytes; with `cfg_wide`=0 it moves 1 byte.
- R3: In immediate mode (`cfg_src_imm`=1, `cfg_calc`=0), no memory read is issued and the loaded source word is written. With `cfg_wide`=0 only its low byte is written, and its high byte has no effect.
- R4: In calculation mode with a memory source (`cfg_calc`=1, `cfg_src_imm`=0), the value written is memory at the source address plus memory at the operand address. The sum wraps modulo 2^8 or 2^16, and the carry is dropped.
- R5: In calculation mode with an immediate source (`cfg_calc`=1, `cfg_src_imm`=1), the value written is the immediate plus memory at the operand address.
- R6: After each transfer, an incremented address advances by 2 when `cfg_wide`=1 and by 1 when `cfg_wide`=0. A fixed address does not move. The operand address advances whenever the memory source advances. Addresses wrap at 2^ADDR_W.
- R7: If the count is 0, a request causes no memory access, no interrupt, and no change of count.
- R8: In single mode (`cfg_burst`=0), each request makes exactly one transfer and lowers `count_out` by 1.
- R9: In burst mode (`cfg_burst`=1), one request runs transfers back to back until `count_out` is 0.
- R10: With `cfg_irq_en`=1, `done_irq` pulses high for one cycle when the count reaches 0. With `cfg_irq_en`=0, it never pulses.
- R11: `irq_block` is high in every cycle in which the engine drives the memory port, starting on the clock edge after an accepted request.
- R12: A request that arrives while a transfer is in progress is held and served after that transfer.
- R13: `cfg_load` has no effect on any register while `irq_block` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Loads all cfg_* values when idle |
| cfg_wide | input | 1 | 1: 16-bit transfers, 0: 8-bit |
| cfg_src_imm | input | 1 | Source word is an immediate value |
| cfg_calc | input | 1 | Write a sum instead of a copy |
| cfg_src_inc | input | 1 | Advance source (and operand) address |
| cfg_dst_inc | input | 1 | Advance destination address |
| cfg_burst | input | 1 | 1: burst mode, 0: single mode |
| cfg_irq_en | input | 1 | Enable end-of-transfer pulse |
| cfg_count | input | CNT_W | Number of transfers |
| cfg_src | input | 16 | Source address or immediate value |
| cfg_opd | input | ADDR_W | Operand address |
| cfg_dst | input | ADDR_W | Destination address |
| xfer_req | input | 1 | Transfer request |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1: write, 0: read |
| mem_wide | output | 1 | Access is 2 bytes |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 16 | Write data, low byte at mem_addr |
| mem_rdata | input | 16 | Read data, valid one cycle after the read |
| irq_block | output | 1 | Interrupt acknowledge blocked (busy) |
| done_irq | output | 1 | One-cycle end-of-transfer pulse |
| count_out | output | CNT_W | Remaining transfer count |

## Verification
The bench builds the engine with ADDR_W=8, so a 256-byte model covers the whole address space. This makes the wrap of an incremented 8-bit destination from FFh to 00h reachable. CNT_W stays at 16, so the zero-count case is the full-width all-zero value. The model counts reads and writes, which shows that immediate mode never reads and that a zero count leaves the port silent.

// File: rtl/dmx_pkg.sv
`timescale 1ns/1ps
package dmx_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RSRC = 2'd1,
    ST_ROPD = 2'd2,
    ST_WR   = 2'd3
  } dmx_state_e;

  typedef struct packed {
    logic wide;
    logic src_imm;
    logic calc;
    logic src_inc;
    logic dst_inc;
    logic burst;
    logic irq_en;
  } dmx_mode_t;
endpackage

// File: rtl/dmx_ptr.sv
`timescale 1ns/1ps
// One address/value register with load and post-transfer advance.
module dmx_ptr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  input  logic         two,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] STEP1 = W'(1);
  localparam logic [W-1:0] STEP2 = W'(2);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (adv)  q <= q + (two ? STEP2 : STEP1);
  end
endmodule

// File: rtl/dmx_alu.sv
`timescale 1ns/1ps
// Operand capture and result formation for copy, immediate and sum paths.
module dmx_alu
  import dmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  dmx_mode_t         mode,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata
);
  localparam int LANE = DATA_W / 2;

  logic [DATA_W-1:0] imm_v, rd_v, a_q, sum, res;

  // narrow mode keeps the low lane only
  assign imm_v = mode.wide ? imm   : {{LANE{1'b0}}, imm[LANE-1:0]};
  assign rd_v  = mode.wide ? rdata : {{LANE{1'b0}}, rdata[LANE-1:0]};

  always_ff @(posedge clk) begin
    if (rst)      a_q <= '0;
    else if (cap) a_q <= mode.src_imm ? imm_v : rd_v;
  end

  assign sum = a_q + rd_v;

  always_comb begin
    if (mode.calc)         res = sum;
    else if (mode.src_imm) res = imm_v;
    else                   res = rd_v;
  end

  assign wdata = mode.wide ? res : {{LANE{1'b0}}, res[LANE-1:0]};
endmodule

// File: rtl/dmx_ctrl.sv
`timescale 1ns/1ps
// Sequencer: mode/count registers, request pending flag, end pulse.
module dmx_ctrl
  import dmx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  dmx_mode_t        cfg_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             xfer_req,
  output dmx_state_e       st,
  output dmx_mode_t        mode,
  output logic [CNT_W-1:0] count,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  dmx_state_e st_n, first_st;
  logic       pend, again;

  always_comb begin
    if (mode.src_imm) first_st = mode.calc ? ST_ROPD : ST_WR;
    else              first_st = ST_RSRC;
  end

  assign again = (count > ONE) && (mode.burst || pend);

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE: if ((xfer_req || pend) && (count != '0)) st_n = first_st;
      ST_RSRC: st_n = mode.calc ? ST_ROPD : ST_WR;
      ST_ROPD: st_n = ST_WR;
      ST_WR:   st_n = again ? first_st : ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      mode  <= '0;
      count <= '0;
      pend  <= 1'b0;
      done  <= 1'b0;
    end else begin
      st   <= st_n;
      done <= 1'b0;
      if (cfg_load && st == ST_IDLE) begin
        mode  <= cfg_mode;
        count <= cfg_count;
      end
      if (st == ST_WR) begin
        count <= count - ONE;
        if (count == ONE) done <= mode.irq_en;
      end
      if (st == ST_IDLE) pend <= 1'b0;
      else if (st == ST_WR && again && !mode.burst) pend <= 1'b0;
      if (xfer_req && st != ST_IDLE) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_xfer_engine.sv
`timescale 1ns/1ps
module dma_xfer_engine
  import dmx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic              cfg_wide,
  input  logic              cfg_src_imm,
  input  logic              cfg_calc,
  input  logic              cfg_src_inc,
  input  logic              cfg_dst_inc,
  input  logic              cfg_burst,
  input  logic              cfg_irq_en,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [15:0]       cfg_src,
  input  logic [ADDR_W-1:0] cfg_opd,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic              xfer_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              irq_block,
  output logic              done_irq,
  output logic [CNT_W-1:0]  count_out
);
  localparam int NPTR  = 3;
  localparam int P_SRC = 0;
  localparam int P_OPD = 1;
  localparam int P_DST = 2;

  dmx_state_e st;
  dmx_mode_t  mode, cfg_mode;
  logic       ld_en;

  logic [DATA_W-1:0] p_ld  [NPTR];
  logic [DATA_W-1:0] p_q   [NPTR];
  logic              p_adv [NPTR];

  assign cfg_mode = '{wide: cfg_wide, src_imm: cfg_src_imm, calc: cfg_calc,
                      src_inc: cfg_src_inc, dst_inc: cfg_dst_inc,
                      burst: cfg_burst, irq_en: cfg_irq_en};

  dmx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .cfg_mode  (cfg_mode),
    .cfg_count (cfg_count),
    .xfer_req  (xfer_req),
    .st        (st),
    .mode      (mode),
    .count     (count_out),
    .done      (done_irq)
  );

  assign ld_en = cfg_load && (st == ST_IDLE);

  assign p_ld[P_SRC] = cfg_src;
  assign p_ld[P_OPD] = DATA_W'(cfg_opd);
  assign p_ld[P_DST] = DATA_W'(cfg_dst);

  // operand address follows the memory source
  assign p_adv[P_SRC] = (st == ST_WR) && mode.src_inc && !mode.src_imm;
  assign p_adv[P_OPD] = (st == ST_WR) && mode.src_inc && !mode.src_imm && mode.calc;
  assign p_adv[P_DST] = (st == ST_WR) && mode.dst_inc;

  for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
    dmx_ptr #(.W(DATA_W)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .load     (ld_en),
      .load_val (p_ld[gi]),
      .adv      (p_adv[gi]),
      .two      (mode.wide),
      .q        (p_q[gi])
    );
  end

  dmx_alu u_alu (
    .clk   (clk),
    .rst   (rst),
    .cap   (st == ST_ROPD),
    .mode  (mode),
    .imm   (p_q[P_SRC]),
    .rdata (mem_rdata),
    .wdata (mem_wdata)
  );

  assign mem_req   = (st != ST_IDLE);
  assign mem_we    = (st == ST_WR);
  assign mem_wide  = mode.wide;
  assign irq_block = (st != ST_IDLE);

  always_comb begin
    unique case (st)
      ST_RSRC: mem_addr = p_q[P_SRC][ADDR_W-1:0];
      ST_ROPD: mem_addr = p_q[P_OPD][ADDR_W-1:0];
      ST_WR:   mem_addr = p_q[P_DST][ADDR_W-1:0];
      default: mem_addr = '0;
    endcase
  end
endmodule

// File: rtl/dmx_checker.sv
`timescale 1ns/1ps
module dmx_checker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_wide,
  input logic [15:0]      mem_wdata,
  input logic             irq_block,
  input logic             done_irq,
  input logic [CNT_W-1:0] count_out
);
  AST_PORT_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> irq_block); // R11
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> count_out == '0); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq); // R10
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$stable(count_out) && !$past(cfg_load)) |-> count_out == $past(count_out) - CNT_W'(1)); // R8
  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> count_out != '0); // R7
  AST_NARROW_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !mem_wide) |-> mem_wdata[15:8] == 8'h00); // R3
endmodule

bind dma_xfer_engine dmx_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_load  (cfg_load),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wide  (mem_wide),
  .mem_wdata (mem_wdata),
  .irq_block (irq_block),
  .done_irq  (done_irq),
  .count_out (count_out)
);

// File: tb/tb_dma_xfer_engine.sv
`timescale 1ns/1ps
module tb_dma_xfer_engine;
  localparam int AW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 0, cfg_wide = 0, cfg_src_imm = 0, cfg_calc = 0;
  logic cfg_src_inc = 0, cfg_dst_inc = 0, cfg_burst = 0, cfg_irq_en = 0;
  logic [CW-1:0] cfg_count = '0;
  logic [15:0]   cfg_src = '0;
  logic [AW-1:0] cfg_opd = '0, cfg_dst = '0;
  logic xfer_req = 0;
  logic mem_req, mem_we, mem_wide, irq_block, done_irq;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [CW-1:0] count_out;

  int total = 0, bad = 0, rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  logic [7:0] mem [256];
  logic       poke_en = 0;
  logic [7:0] poke_addr = '0, poke_data = '0;
  bit         finished = 0;

  always #10 clk = ~clk;

  dma_xfer_engine #(.ADDR_W(AW), .CNT_W(CW)) dut (.*);

  // byte-addressed little-endian memory, one-cycle read latency
  always @(posedge clk) begin
    if (poke_en) mem[poke_addr] <= poke_data;
    if (mem_req && mem_we) begin
      mem[mem_addr] <= mem_wdata[7:0];
      if (mem_wide) mem[8'(mem_addr + 1)] <= mem_wdata[15:8];
      wr_cnt <= wr_cnt + 1;
    end else if (mem_req) begin
      mem_rdata <= mem_wide ? {mem[8'(mem_addr + 1)], mem[mem_addr]} : {8'h00, mem[mem_addr]};
      rd_cnt <= rd_cnt + 1;
    end
  end

  always @(negedge clk) if (done_irq) done_cnt <= done_cnt + 1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); poke_en = 1; poke_addr = a; poke_data = d;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic setup(input bit wide, imm, calc, sinc, dinc, burst, irqen,
                       input int cnt, input logic [15:0] src,
                       input logic [7:0] opd, input logic [7:0] dst);
    @(negedge clk);
    cfg_wide = wide; cfg_src_imm = imm; cfg_calc = calc; cfg_src_inc = sinc;
    cfg_dst_inc = dinc; cfg_burst = burst; cfg_irq_en = irqen;
    cfg_count = CW'(cnt); cfg_src = src; cfg_opd = opd; cfg_dst = dst;
    cfg_load = 1;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 400 && quiet < 3; i++) begin
      @(negedge clk);
      quiet = irq_block ? 0 : quiet + 1;
    end
  endtask

  task automatic go();
    @(negedge clk); xfer_req = 1;
    @(negedge clk); xfer_req = 0;
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R1 mem_req", int'(mem_req), 0);
    chk("R1 irq_block", int'(irq_block), 0);
    chk("R1 done_irq", int'(done_irq), 0);
    chk("R1 count", int'(count_out), 0);
  endtask

  task automatic t_copy16_burst();
    poke(8'h10, 8'h11); poke(8'h11, 8'h22); poke(8'h12, 8'h33); poke(8'h13, 8'h44);
    setup(1, 0, 0, 1, 1, 1, 1, 2, 16'h0010, 8'h00, 8'h40);
    go();
    chk("R2 copy16 b0", int'(mem[8'h40]), 'h11);
    chk("R2 copy16 b1", int'(mem[8'h41]), 'h22);
    chk("R6 copy16 step2 b2", int'(mem[8'h42]), 'h33);
    chk("R6 copy16 step2 b3", int'(mem[8'h43]), 'h44);
    chk("R9 burst count", int'(count_out), 0);
    chk("R10 done pulses", done_cnt, 1);
  endtask

  task automatic t_copy8_single();
    poke(8'h20, 8'h5C);
    setup(0, 0, 0, 0, 1, 0, 1, 3, 16'h0020, 8'h00, 8'h50);
    go();
    chk("R8 single count 1st", int'(count_out), 2);
    chk("R8 single one write", int'(mem[8'h51]), 0);
    go();
    chk("R8 single count 2nd", int'(count_out), 1);
    chk("R10 no pulse before zero", done_cnt, 1);
    go();
    chk("R8 single count 3rd", int'(count_out), 0);
    chk("R2 copy8 fixed src", int'(mem[8'h52]), 'h5C);
    chk("R6 dst step1", int'(mem[8'h51]), 'h5C);
    chk("R10 pulse at zero", done_cnt, 2);
  endtask

  task automatic t_imm();
    int rd0 = rd_cnt;
    setup(0, 1, 0, 0, 1, 1, 0, 2, 16'hABCD, 8'h00, 8'h60);
    go();
    chk("R3 imm8 low byte", int'(mem[8'h60]), 'hCD);
    chk("R3 imm8 second", int'(mem[8'h61]), 'hCD);
    chk("R3 imm8 high ignored", int'(mem[8'h62]), 0);
    chk("R3 imm no reads", rd_cnt - rd0, 0);
    setup(1, 1, 0, 0, 0, 1, 0, 3, 16'h1234, 8'h00, 8'h70);
    go();
    chk("R3 imm16 lo", int'(mem[8'h70]), 'h34);
    chk("R3 imm16 hi", int'(mem[8'h71]), 'h12);
    chk("R6 fixed dst", int'(mem[8'h72]), 0);
    chk("R10 disabled no pulse", done_cnt, 2);
  endtask

  task automatic t_calc();
    poke(8'h80, 8'hF0); poke(8'h81, 8'h05); poke(8'h90, 8'h20); poke(8'h91, 8'h07);
    setup(0, 0, 1, 1, 1, 1, 0, 2, 16'h0080, 8'h90, 8'hA0);
    go();
    chk("R4 sum8 wrap", int'(mem[8'hA0]), 'h10);
    chk("R6 opd follows src", int'(mem[8'hA1]), 'h0C);
    poke(8'h84, 8'hFF); poke(8'h85, 8'hFF); poke(8'h94, 8'h03); poke(8'h95, 8'h00);
    setup(1, 0, 1, 0, 0, 1, 0, 1, 16'h0084, 8'h94, 8'hA8);
    go();
    chk("R4 sum16 wrap", int'({mem[8'hA9], mem[8'hA8]}), 'h0002);
    poke(8'hB0, 8'h34); poke(8'hB1, 8'h02);
    setup(1, 1, 1, 1, 1, 1, 0, 2, 16'h1000, 8'hB0, 8'hB8);
    go();
    chk("R5 imm+mem first", int'({mem[8'hB9], mem[8'hB8]}), 'h1234);
    chk("R5 imm+mem second", int'({mem[8'hBB], mem[8'hBA]}), 'h1234);
  endtask

  task automatic t_zero();
    int rd0 = rd_cnt, wr0 = wr_cnt, d0 = done_cnt;
    setup(1, 1, 0, 0, 1, 1, 1, 0, 16'hEEEE, 8'h00, 8'hF0);
    go();
    chk("R7 no access", (rd_cnt - rd0) + (wr_cnt - wr0), 0);
    chk("R7 count stays", int'(count_out), 0);
    chk("R7 no irq", done_cnt - d0, 0);
  endtask

  task automatic t_pending();
    poke(8'hC0, 8'h01); poke(8'hC1, 8'h02); poke(8'hC2, 8'h03);
    setup(0, 0, 0, 1, 1, 0, 0, 3, 16'h00C0, 8'h00, 8'hD0);
    @(negedge clk); xfer_req = 1;
    @(negedge clk);
    chk("R11 block while busy", int'(irq_block), 1);
    // second request arrives while the first is in progress
    @(negedge clk); xfer_req = 0;
    wait_idle();
    chk("R12 pending served count", int'(count_out), 1);
    chk("R12 first write", int'(mem[8'hD0]), 'h01);
    chk("R12 second write", int'(mem[8'hD1]), 'h02);
    chk("R12 no third", int'(mem[8'hD2]), 0);
    chk("R11 block released", int'(irq_block), 0);
  endtask

  task automatic t_load_busy();
    setup(1, 1, 0, 0, 0, 1, 0, 4, 16'h5A5A, 8'h00, 8'hE0);
    @(negedge clk); xfer_req = 1;
    @(negedge clk); xfer_req = 0;
    cfg_count = CW'(9); cfg_dst = 8'hE8; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
    wait_idle();
    chk("R13 count unaffected", int'(count_out), 0);
    chk("R13 dst unaffected", int'(mem[8'hE8]), 0);
    chk("R13 dst written", int'(mem[8'hE0]), 'h5A);
  endtask

  task automatic t_wrap();
    setup(0, 1, 0, 0, 1, 1, 0, 2, 16'h0077, 8'h00, 8'hFF);
    go();
    chk("R6 wrap last", int'(mem[8'hFF]), 'h77);
    chk("R6 wrap first", int'(mem[8'h00]), 'h77);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_copy16_burst();
    t_copy8_single();
    t_imm();
    t_calc();
    t_zero();
    t_pending();
    t_load_busy();
    t_wrap();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule